// File: doc/BRIEF.md
# Chained Debug Trace and Trigger On-Ramp Stage

This block is one link in a chain of debug stages. Each stage receives an 88-bit trace bus and a 12-bit trigger bus from the stage before it. It passes them on to the next stage after one register. Each fixed-width slice of either bus can be replaced by a slice of a local signal group. The trace bus is cut into four 22-bit slices and the trigger bus into two 6-bit slices. A local group is picked by one of two local selectors.

A 32-bit configuration word programs the stage. It holds two 16-bit control sets, set 0 in bits [15:0] and set 1 in bits [31:16], one for each local selector. Within a set, the bit positions are counted from the set's own bit 0:

| Bits | Use |
|---|---|
| [2:0] | which of eight local trace groups the selector takes |
| [6:3] | trace on-ramp mask, bit 3+s claims trace slice s |
| [8:7] | which of four local trigger groups the selector takes |
| [10:9] | trigger on-ramp mask, bit 9+t claims trigger slice t |
| [15:11] | reserved |

Trace slice s covers bus bits [22s+21:22s]. Trigger slice t covers bits [6t+5:6t]. Local trace group g sits at bits [88g+87:88g] of the local trace input. Local trigger group g sits at bits [12g+11:12g] of the local trigger input.

After reset every mask bit is clear, so the chain forwards upstream data unchanged. Software turns a stage on by writing the configuration word. Each stage adds one cycle of latency.

Top module: `trace_onramp_stage`

## Requirements
- R1: While `rst_n` is low, `trace_o`, `trig_o` and `cfg_rdata` are all zero. After reset every slice is in pass-through.
- R2: A slice claimed by neither set carries the upstream slice, one clock after the upstream value is sampled.
- R3: Trace slice s is claimed by set 0 when word bit 3+s is set. It then carries bits [22s+21:22s] of the local trace group chosen by word bits [2:0], one clock later.
- R4: Trigger slice t is claimed by set 0 when word bit 9+t is set. It then carries bits [6t+5:6t] of the local trigger group chosen by word bits [8:7], one clock later.
- R5: Set 1 uses the same layout 16 bits higher. Bits [18:16] select its trace group, bits [22:19] are its trace mask, bits [24:23] select its trigger group, and bits [26:25] are its trigger mask.
- R6: When both sets claim the same slice, set 0 supplies it.
- R7: Word bits [15:11] and [31:27] are reserved. They read back as zero and change no output.
- R8: A word written with `cfg_we` at a clock edge appears on `cfg_rdata` after that edge. It steers the data sampled at the next edge. Data sampled at the write edge still uses the previous word.
- R9: Each slice is selected on its own. Claiming one slice leaves the other slices of the same bus on upstream data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word, reserved bits zero |
| up_trace_i | input | 88 | Trace bus from the previous stage |
| up_trig_i | input | 12 | Trigger bus from the previous stage |
| local_trace_i | input | 704 | Eight local trace groups of 88 bits |
| local_trig_i | input | 48 | Four local trigger groups of 12 bits |
| trace_o | output | 88 | Registered trace bus to the next stage |
| trig_o | output | 12 | Registered trigger bus to the next stage |

## Verification
A corrupted stored control bit shows on `cfg_rdata` on the very cycle after the write. It reaches the buses one cycle later as a whole slice of the wrong source. That source is either upstream data where local data was asked for, or the reverse.

A wrong group index or a wrong overlap priority gives data that differs from the expected group across all 22 or 6 bits of the slice. Random per-cycle patterns make such a slice mismatch at the first compare. A broken output register shifts every comparison by one cycle, so it is caught on the first cycle after reset.

// File: rtl/trace_onramp_pkg.sv
package trace_onramp_pkg;

    localparam int TRACE_SLICES = 4;
    localparam int TRIG_SLICES  = 2;
    localparam int TRACE_GROUPS = 8;
    localparam int TRIG_GROUPS  = 4;
    localparam int TRACE_SEL_W  = $clog2(TRACE_GROUPS);
    localparam int TRIG_SEL_W   = $clog2(TRIG_GROUPS);
    localparam int CTL_W        = 16;
    localparam int N_SETS       = 2;
    localparam int CFG_W        = CTL_W * N_SETS;
    localparam int CTL_USED     = TRACE_SEL_W + TRACE_SLICES + TRIG_SEL_W + TRIG_SLICES;
    localparam int RSVD_W       = CTL_W - CTL_USED;

    // One control set; trace_sel occupies the lowest bits.
    typedef struct packed {
        logic [RSVD_W-1:0]       rsvd;
        logic [TRIG_SLICES-1:0]  trig_mask;
        logic [TRIG_SEL_W-1:0]   trig_sel;
        logic [TRACE_SLICES-1:0] trace_mask;
        logic [TRACE_SEL_W-1:0]  trace_sel;
    } mux_ctl_t;

    function automatic mux_ctl_t scrub_ctl(mux_ctl_t c);
        mux_ctl_t r;
        r      = c;
        r.rsvd = '0;
        return r;
    endfunction

endpackage

// File: rtl/onramp_cfg_reg.sv
module onramp_cfg_reg
    import trace_onramp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CFG_W-1:0]        wdata,
    output mux_ctl_t [N_SETS-1:0]   ctl_o,
    output logic [CFG_W-1:0]        rdata_o
);

    typedef struct packed {
        mux_ctl_t [N_SETS-1:0] set;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int k = 0; k < N_SETS; k++) begin
                st_d.set[k] = scrub_ctl(mux_ctl_t'(wdata[k*CTL_W +: CTL_W]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o   = st_q.set;
    assign rdata_o = st_q;

endmodule

// File: rtl/onramp_group_sel.sv
module onramp_group_sel #(
    parameter int W     = 88,
    parameter int N     = 8,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N*W-1:0]   groups_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     grp_o
);

    always_comb begin
        grp_o = '0;
        for (int g = 0; g < N; g++) begin
            if (sel_i == SEL_W'(g)) grp_o = groups_i[g*W +: W];
        end
    end

endmodule

// File: rtl/onramp_slice_merge.sv
module onramp_slice_merge #(
    parameter int W      = 88,
    parameter int SLICES = 4,
    localparam int SW    = W / SLICES
) (
    input  logic [W-1:0]      up_i,
    input  logic [W-1:0]      pri_i,
    input  logic [W-1:0]      sec_i,
    input  logic [SLICES-1:0] pri_en_i,
    input  logic [SLICES-1:0] sec_en_i,
    output logic [W-1:0]      out_o
);

    // Primary set wins when both claim a slice.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        assign out_o[s*SW +: SW] = pri_en_i[s] ? pri_i[s*SW +: SW] :
                                   sec_en_i[s] ? sec_i[s*SW +: SW] :
                                                 up_i[s*SW +: SW];
    end

endmodule

// File: rtl/trace_onramp_stage.sv
module trace_onramp_stage
    import trace_onramp_pkg::*;
#(
    parameter int TRACE_W = 88,
    parameter int TRIG_W  = 12,
    localparam int LT_W   = TRACE_W * TRACE_GROUPS,
    localparam int LG_W   = TRIG_W * TRIG_GROUPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [TRACE_W-1:0] up_trace_i,
    input  logic [TRIG_W-1:0]  up_trig_i,
    input  logic [LT_W-1:0]    local_trace_i,
    input  logic [LG_W-1:0]    local_trig_i,
    output logic [TRACE_W-1:0] trace_o,
    output logic [TRIG_W-1:0]  trig_o
);

    mux_ctl_t [N_SETS-1:0]   ctl;
    logic [TRACE_W-1:0]      trace_cand [N_SETS];
    logic [TRIG_W-1:0]       trig_cand  [N_SETS];
    logic [TRACE_W-1:0]      trace_merged;
    logic [TRIG_W-1:0]       trig_merged;

    onramp_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .ctl_o   (ctl),
        .rdata_o (cfg_rdata)
    );

    for (genvar k = 0; k < N_SETS; k++) begin : g_set
        onramp_group_sel #(.W(TRACE_W), .N(TRACE_GROUPS)) u_trace_sel (
            .groups_i (local_trace_i),
            .sel_i    (ctl[k].trace_sel),
            .grp_o    (trace_cand[k])
        );
        onramp_group_sel #(.W(TRIG_W), .N(TRIG_GROUPS)) u_trig_sel (
            .groups_i (local_trig_i),
            .sel_i    (ctl[k].trig_sel),
            .grp_o    (trig_cand[k])
        );
    end

    onramp_slice_merge #(.W(TRACE_W), .SLICES(TRACE_SLICES)) u_trace_merge (
        .up_i     (up_trace_i),
        .pri_i    (trace_cand[0]),
        .sec_i    (trace_cand[1]),
        .pri_en_i (ctl[0].trace_mask),
        .sec_en_i (ctl[1].trace_mask),
        .out_o    (trace_merged)
    );

    onramp_slice_merge #(.W(TRIG_W), .SLICES(TRIG_SLICES)) u_trig_merge (
        .up_i     (up_trig_i),
        .pri_i    (trig_cand[0]),
        .sec_i    (trig_cand[1]),
        .pri_en_i (ctl[0].trig_mask),
        .sec_en_i (ctl[1].trig_mask),
        .out_o    (trig_merged)
    );

    typedef struct packed {
        logic [TRACE_W-1:0] trace;
        logic [TRIG_W-1:0]  trig;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.trace = trace_merged;
        out_d.trig  = trig_merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign trace_o = out_q.trace;
    assign trig_o  = out_q.trig;

endmodule

// File: rtl/trace_onramp_stage_chk.sv
module trace_onramp_stage_chk
    import trace_onramp_pkg::*;
#(
    parameter int TRACE_W = 88,
    parameter int TRIG_W  = 12
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cfg_we,
    input logic [CFG_W-1:0]                  cfg_wdata,
    input logic [CFG_W-1:0]                  cfg_rdata,
    input logic [TRACE_W-1:0]                up_trace_i,
    input logic [TRIG_W-1:0]                 up_trig_i,
    input logic [TRACE_W*TRACE_GROUPS-1:0]   local_trace_i,
    input logic [TRIG_W*TRIG_GROUPS-1:0]     local_trig_i,
    input logic [TRACE_W-1:0]                trace_o,
    input logic [TRIG_W-1:0]                 trig_o
);

    localparam int SW  = TRACE_W / TRACE_SLICES;
    localparam int GW  = TRIG_W / TRIG_SLICES;
    localparam int TOP = TRACE_SLICES - 1;

    mux_ctl_t c0, c1, w0, w1;
    assign c0 = cfg_rdata[CTL_W-1:0];
    assign c1 = cfg_rdata[CFG_W-1:CTL_W];
    assign w0 = cfg_wdata[CTL_W-1:0];
    assign w1 = cfg_wdata[CFG_W-1:CTL_W];

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (trace_o == '0 && trig_o == '0 && cfg_rdata == '0));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata == '0) |=> (trace_o == $past(up_trace_i) && trig_o == $past(up_trig_i)));

    a_r3_trace_set0: assert property (@(posedge clk) disable iff (!rst_n)
        c0.trace_mask[0] |=> trace_o[SW-1:0] == $past(local_trace_i[c0.trace_sel*TRACE_W +: SW]));

    a_r4_trig_set0: assert property (@(posedge clk) disable iff (!rst_n)
        c0.trig_mask[0] |=> trig_o[GW-1:0] == $past(local_trig_i[c0.trig_sel*TRIG_W +: GW]));

    a_r5_trace_set1: assert property (@(posedge clk) disable iff (!rst_n)
        (!c0.trace_mask[TOP] && c1.trace_mask[TOP]) |=>
        trace_o[TOP*SW +: SW] == $past(local_trace_i[c1.trace_sel*TRACE_W + TOP*SW +: SW]));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (c0.rsvd == '0 && c1.rsvd == '0));

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (c0 == $past(scrub_ctl(w0)) && c1 == $past(scrub_ctl(w1))));

endmodule

bind trace_onramp_stage trace_onramp_stage_chk #(.TRACE_W(TRACE_W), .TRIG_W(TRIG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .up_trace_i    (up_trace_i),
    .up_trig_i     (up_trig_i),
    .local_trace_i (local_trace_i),
    .local_trig_i  (local_trig_i),
    .trace_o       (trace_o),
    .trig_o        (trig_o)
);

// File: tb/trace_onramp_stage_test.sv
module trace_onramp_stage_test;

    localparam int CLK_PERIOD = 10;
    localparam int TW   = 88;
    localparam int GWD  = 12;
    localparam int NTG  = 8;
    localparam int NGG  = 4;
    localparam int TSW  = 22;
    localparam int GSW  = 6;
    localparam logic [31:0] RSV = 32'hF800_F800;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic [TW-1:0]    up_trace_i = '0;
    logic [GWD-1:0]   up_trig_i = '0;
    logic [TW*NTG-1:0] local_trace_i = '0;
    logic [GWD*NGG-1:0] local_trig_i = '0;
    logic [TW-1:0]    trace_o;
    logic [GWD-1:0]   trig_o;

    int n_cmp  = 0;
    int n_fail = 0;
    logic [31:0] cfg_m = '0;

    typedef struct {
        logic [TW-1:0]  tr;
        logic [GWD-1:0] tg;
        logic [31:0]    rd;
        string          tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_onramp_stage uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .up_trace_i    (up_trace_i),
        .up_trig_i     (up_trig_i),
        .local_trace_i (local_trace_i),
        .local_trig_i  (local_trig_i),
        .trace_o       (trace_o),
        .trig_o        (trig_o)
    );

    function automatic logic [TW-1:0] exp_trace(logic [31:0] c, logic [TW-1:0] up,
                                                 logic [TW*NTG-1:0] loc);
        logic [TW-1:0] r;
        for (int s = 0; s < 4; s++) begin
            if (c[3+s])       r[s*TSW +: TSW] = loc[int'(c[2:0])*TW + s*TSW +: TSW];
            else if (c[19+s]) r[s*TSW +: TSW] = loc[int'(c[18:16])*TW + s*TSW +: TSW];
            else              r[s*TSW +: TSW] = up[s*TSW +: TSW];
        end
        return r;
    endfunction

    function automatic logic [GWD-1:0] exp_trig(logic [31:0] c, logic [GWD-1:0] up,
                                                logic [GWD*NGG-1:0] loc);
        logic [GWD-1:0] r;
        for (int t = 0; t < 2; t++) begin
            if (c[9+t])       r[t*GSW +: GSW] = loc[int'(c[8:7])*GWD + t*GSW +: GSW];
            else if (c[25+t]) r[t*GSW +: GSW] = loc[int'(c[24:23])*GWD + t*GSW +: GSW];
            else              r[t*GSW +: GSW] = up[t*GSW +: GSW];
        end
        return r;
    endfunction

    task automatic scramble();
        logic [95:0] w;
        w = {$urandom(), $urandom(), $urandom()};
        up_trace_i = w[TW-1:0];
        up_trig_i  = GWD'($urandom());
        for (int g = 0; g < NTG; g++) begin
            w = {$urandom(), $urandom(), $urandom()};
            local_trace_i[g*TW +: TW] = w[TW-1:0];
        end
        for (int g = 0; g < NGG; g++) local_trig_i[g*GWD +: GWD] = GWD'($urandom());
    endtask

    task automatic drive(string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0;
        scramble();
        e.tr  = exp_trace(cfg_m, up_trace_i, local_trace_i);
        e.tg  = exp_trig(cfg_m, up_trig_i, local_trig_i);
        e.rd  = cfg_m;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Write and drive data in the same cycle: data uses the old word (R8).
    task automatic write_drive(logic [31:0] word, string tag);
        exp_t e;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = word;
        scramble();
        e.tr  = exp_trace(cfg_m, up_trace_i, local_trace_i);
        e.tg  = exp_trig(cfg_m, up_trig_i, local_trig_i);
        cfg_m = word & ~RSV;
        e.rd  = cfg_m;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(e.tag, 128'(trace_o), 128'(e.tr), "trace_o");
                check(e.tag, 128'(trig_o), 128'(e.tg), "trig_o");
                check(e.tag, 128'(cfg_rdata), 128'(e.rd), "cfg_rdata");
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD*50000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin : stim
        // R1: reset state with busy inputs
        scramble();
        repeat (3) @(negedge clk);
        check("R1", 128'(trace_o), 128'(0), "trace_o in reset");
        check("R1", 128'(trig_o), 128'(0), "trig_o in reset");
        check("R1", 128'(cfg_rdata), 128'(0), "cfg_rdata in reset");
        rst_n = 1'b1;

        // R1/R2: default pass-through
        repeat (4) drive("R2");

        // R8: write set 0 (trace sel 5, mask 0101; trig sel 2, mask 01)
        write_drive(32'h0000_032D, "R8");
        repeat (4) drive("R3");
        repeat (2) drive("R4");

        // R9: only top trace slice, only upper trigger slice, set 0 sel 3
        write_drive(32'h0000_0443 | 32'h0000_0100, "R8");
        repeat (3) drive("R9");

        // R5/R6: set 0 sel 1 mask 0011; set 1 sel 6 mask 0110 trig sel 3 mask 10
        write_drive({5'b0, 2'b10, 2'b11, 4'b0110, 3'd6, 5'b0, 2'b00, 2'b00, 4'b0011, 3'd1}, "R8");
        repeat (3) drive("R6");
        // set 1 alone on all slices
        write_drive({5'b0, 2'b11, 2'b01, 4'b1111, 3'd2, 16'h0000}, "R8");
        repeat (3) drive("R5");
        // both sets claim every slice: set 0 wins
        write_drive({5'b0, 2'b11, 2'b10, 4'b1111, 3'd7, 5'b0, 2'b11, 2'b01, 4'b1111, 3'd4}, "R8");
        repeat (3) drive("R6");

        // R7: reserved-only write behaves like all zero
        write_drive(32'hF800_F800, "R7");
        repeat (3) drive("R7");
        // R7: all ones stores with reserved cleared
        write_drive(32'hFFFF_FFFF, "R7");
        repeat (2) drive("R7");

        // R3: sweep every trace group on all slices
        for (int g = 0; g < 8; g++) begin
            write_drive(32'h0000_0078 | 32'(g), "R8");
            repeat (2) drive("R3");
        end
        // R4: sweep every trigger group on both trigger slices
        for (int g = 0; g < 4; g++) begin
            write_drive(32'h0000_0600 | (32'(g) << 7), "R8");
            repeat (2) drive("R4");
        end

        // back to pass-through
        write_drive(32'h0000_0000, "R8");
        repeat (3) drive("R2");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule